// File: doc/BRIEF.md
# Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. It latches requests from eight lines into a request register. It filters them through a per-line mask and compares the best remaining request with the levels the processor is already servicing. When the pending request outranks all of them, it raises a single interrupt line. When the processor acknowledges, the block records the winning level as in service, drops its request bit and reports which level won. End-of-interrupt commands later retire in-service levels, either by naming one or by taking the most urgent one. An automatic mode retires the level at acknowledge time.

Trigger style, priority scheme and automatic retirement are configuration inputs, so a surrounding bus interface can program them. Under fixed priority line 0 is the most urgent and line 7 the least. Under rotating priority, the level that has just been retired becomes the least urgent. The mask can be rewritten in any cycle.

Top module: `pic_core`

## Requirements
- R1: During and directly after synchronous reset, the request and in-service registers read 0x00, the mask reads 0xFF (every line masked) and `int_req` is low.
- R2: Mask bit n blocks line n from raising `int_req` and from winning an acknowledge. A write on `mask_we` takes effect in the next cycle, and a masked line still records its request in `req_bits`.
- R3: With `cfg_level_trig` = 0 (edge), a 0-to-1 change on `irq_in[n]` sets `req_bits[n]` one cycle later. The bit stays set only while the input stays high, and the line has to return to 0 before it can set the bit again.
- R4: With `cfg_level_trig` = 1 (level), `req_bits[n]` copies `irq_in[n]` one cycle later, except in the cycle after that line is acknowledged, when it reads 0.
- R5: `int_req` is high exactly when an unmasked request bit is set whose priority is higher than that of every set in-service bit (or no in-service bit is set).
- R6: An `int_ack` seen while `int_req` is high sets the in-service bit of the most urgent unmasked request and clears its request bit. It pulses `grant_valid` for one cycle with that level on `grant_level`. An `int_ack` while `int_req` is low changes nothing.
- R7: With `cfg_rotate` = 0, priority is fixed: line 0 is the most urgent and line 7 the least.
- R8: With `cfg_rotate` = 1, the level that was just retired becomes the least urgent and the level above it (modulo 8) becomes the most urgent. A level is retired by an end-of-interrupt, or by an acknowledge when automatic retirement is on.
- R9: A command with `eoi_valid` = 1 and `eoi_specific` = 0 clears the in-service bit of the most urgent level in service.
- R10: A command with `eoi_valid` = 1 and `eoi_specific` = 1 clears the in-service bit numbered by `eoi_level`. It leaves the other in-service bits as they were.
- R11: With `cfg_auto_eoi` = 1, an acknowledge leaves the in-service register unchanged while still granting the level and clearing its request bit.
- R12: A request that falls before it is acknowledged clears its request bit and never sets an in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, bit n is line n |
| mask_we | input | 1 | Load the mask from `mask_wdata` |
| mask_wdata | input | 8 | New mask, bit n set masks line n |
| cfg_level_trig | input | 1 | 1 = level triggered, 0 = edge triggered |
| cfg_rotate | input | 1 | 1 = rotating priority, 0 = fixed |
| cfg_auto_eoi | input | 1 | 1 = retire level at acknowledge |
| int_ack | input | 1 | Processor acknowledge, one cycle |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_specific | input | 1 | 1 = retire `eoi_level`, 0 = retire most urgent |
| eoi_level | input | 3 | Level named by a specific command |
| int_req | output | 1 | Interrupt request to the processor |
| grant_valid | output | 1 | One-cycle pulse after an accepted acknowledge |
| grant_level | output | 3 | Level granted by the last acknowledge |
| req_bits | output | 8 | Request register |
| srv_bits | output | 8 | In-service register |
| mask_bits | output | 8 | Mask register |

## Verification
The hardest state to reach is a set of nested in-service levels under a rotated priority base. Several levels must be in service at once, each one acknowledged while a more urgent level was still pending. At the same time the rotation pointer must sit away from its reset position, so that the pending-versus-in-service comparison wraps around level 7. Directed sequences first build two-deep nesting and a rotation explicitly. Thousands of random cycles then mix sparse line toggles, frequent acknowledges, both kinds of end-of-interrupt and occasional mask rewrites, with the configuration redrawn every 200 cycles, and each cycle is compared with a reference model in the bench.

// File: rtl/pic_pkg.sv
package pic_pkg;
    // The number of lines must be a power of two: priority ranks wrap by index width.
    localparam int N_IRQ = 8;
    localparam int IDX_W = $clog2(N_IRQ);

    typedef logic [N_IRQ-1:0] irq_vec_t;
    typedef logic [IDX_W-1:0] irq_idx_t;

    typedef struct packed {
        logic     valid;
        irq_idx_t idx;
    } pick_t;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    localparam irq_idx_t LOWEST_FIXED = irq_idx_t'(N_IRQ - 1);

    // Rank 0 is most urgent; the level held in `low` has the worst rank.
    function automatic irq_idx_t rank_of(irq_idx_t idx, irq_idx_t low);
        return irq_idx_t'(idx - low - irq_idx_t'(1));
    endfunction

    function automatic irq_vec_t bit_of(irq_idx_t i);
        return irq_vec_t'(1) << i;
    endfunction

    // Walk from the level just above `low` upward and return the first set bit.
    function automatic pick_t pick_first(irq_vec_t vec, irq_idx_t low);
        pick_t r;
        r = '0;
        for (int k = 0; k < N_IRQ; k++) begin
            irq_idx_t c;
            c = irq_idx_t'(low + irq_idx_t'(k) + irq_idx_t'(1));
            if (!r.valid && vec[c]) begin
                r.valid = 1'b1;
                r.idx   = c;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t irq_in,
    input  trig_e    trig,
    input  irq_vec_t ack_clr,
    output irq_vec_t irr
);
    irq_vec_t irq_d;
    irq_vec_t irr_n;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        logic rise;
        assign rise = irq_in[g] & ~irq_d[g];
        always_comb begin
            if (trig == TRIG_LEVEL) begin
                irr_n[g] = irq_in[g] & ~ack_clr[g];
            end else begin
                // Edge mode: latch on rise, drop when the line is withdrawn.
                irr_n[g] = ((irr[g] & ~ack_clr[g]) | rise) & irq_in[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_d <= '0;
            irr   <= '0;
        end else begin
            irq_d <= irq_in;
            irr   <= irr_n;
        end
    end

    // R12: no request bit survives a cycle whose input was low
    assert_req_needs_line_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irr & ~$past(irq_in)) == '0));

    // R3: in edge mode a bit can only appear after a rising edge
    assert_edge_needs_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (trig == TRIG_EDGE) |=> ((irr & ~$past(irr) & $past(irq_d)) == '0));
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
    import pic_pkg::*;
(
    input  irq_vec_t vec,
    input  irq_idx_t low,
    output pick_t    top,
    output irq_idx_t top_rank
);
    always_comb begin
        top      = pick_first(vec, low);
        top_rank = rank_of(top.idx, low);
    end
endmodule

// File: rtl/pic_service.sv
module pic_service
    import pic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  irq_idx_t win,
    input  logic     auto_eoi,
    input  logic     rotate,
    input  logic     eoi_valid,
    input  logic     eoi_specific,
    input  irq_idx_t eoi_level,
    input  pick_t    srv_top,
    output irq_vec_t isr,
    output irq_idx_t low_ptr,
    output logic     grant_valid,
    output irq_idx_t grant_level
);
    irq_vec_t isr_set;
    irq_vec_t isr_clr;
    irq_vec_t isr_n;
    irq_idx_t eoi_tgt;
    logic     eoi_hit;
    irq_idx_t low_n;

    always_comb begin
        isr_set = (take && !auto_eoi) ? bit_of(win) : '0;
        eoi_tgt = eoi_specific ? eoi_level : srv_top.idx;
        eoi_hit = eoi_valid && isr[eoi_tgt];
        isr_clr = eoi_hit ? bit_of(eoi_tgt) : '0;
        isr_n   = (isr & ~isr_clr) | isr_set;
        low_n   = low_ptr;
        if (rotate) begin
            if (take && auto_eoi) begin
                low_n = win;
            end else if (eoi_hit) begin
                low_n = eoi_tgt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr         <= '0;
            low_ptr     <= LOWEST_FIXED;
            grant_valid <= 1'b0;
            grant_level <= '0;
        end else begin
            isr         <= isr_n;
            low_ptr     <= low_n;
            grant_valid <= take;
            if (take) begin
                grant_level <= win;
            end
        end
    end

    // R10: a named level is out of service after its command
    assert_spec_eoi_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && eoi_specific && !take) |=> !isr[$past(eoi_level)]);

    // R11: automatic retirement never grows the in-service set
    assert_auto_no_growth_R11: assert property (@(posedge clk) disable iff (rst)
        (auto_eoi && take) |=> ($countones(isr) <= $past($countones(isr))));

    // R9: a non-specific command removes exactly one level when any is in service
    assert_nonspec_one_R9: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !eoi_specific && !take && (isr != '0))
        |=> ($countones(isr) + 1 == $past($countones(isr))));
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] irq_in,
    input  logic       mask_we,
    input  logic [7:0] mask_wdata,
    input  logic       cfg_level_trig,
    input  logic       cfg_rotate,
    input  logic       cfg_auto_eoi,
    input  logic       int_ack,
    input  logic       eoi_valid,
    input  logic       eoi_specific,
    input  logic [2:0] eoi_level,
    output logic       int_req,
    output logic       grant_valid,
    output logic [2:0] grant_level,
    output logic [7:0] req_bits,
    output logic [7:0] srv_bits,
    output logic [7:0] mask_bits
);
    irq_vec_t mask_q;
    irq_vec_t irr;
    irq_vec_t isr;
    irq_vec_t pending;
    irq_vec_t ack_clr;
    irq_idx_t low_ptr;
    irq_idx_t eff_low;
    pick_t    pend_top;
    pick_t    srv_top;
    irq_idx_t pend_rank;
    irq_idx_t srv_rank;
    logic     take;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    assign eff_low = cfg_rotate ? low_ptr : LOWEST_FIXED;
    assign pending = irr & ~mask_q;

    pic_prio_pick u_pend_pick (
        .vec      (pending),
        .low      (eff_low),
        .top      (pend_top),
        .top_rank (pend_rank)
    );

    pic_prio_pick u_srv_pick (
        .vec      (isr),
        .low      (eff_low),
        .top      (srv_top),
        .top_rank (srv_rank)
    );

    always_comb begin
        int_req = pend_top.valid && (!srv_top.valid || (pend_rank < srv_rank));
        take    = int_ack && int_req;
        ack_clr = take ? bit_of(pend_top.idx) : '0;
    end

    pic_req_latch u_req (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .trig    (trig_e'(cfg_level_trig)),
        .ack_clr (ack_clr),
        .irr     (irr)
    );

    pic_service u_srv (
        .clk          (clk),
        .rst          (rst),
        .take         (take),
        .win          (pend_top.idx),
        .auto_eoi     (cfg_auto_eoi),
        .rotate       (cfg_rotate),
        .eoi_valid    (eoi_valid),
        .eoi_specific (eoi_specific),
        .eoi_level    (eoi_level),
        .srv_top      (srv_top),
        .isr          (isr),
        .low_ptr      (low_ptr),
        .grant_valid  (grant_valid),
        .grant_level  (grant_level)
    );

    assign req_bits  = irr;
    assign srv_bits  = isr;
    assign mask_bits = mask_q;

    // R5: a raised interrupt always has an unmasked request behind it
    assert_int_has_source_R5: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((req_bits & ~mask_bits) != 8'h00));

    // R6: an acknowledge with no interrupt raised is ignored
    assert_stray_ack_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_req && !eoi_valid) |=> ($stable(srv_bits) && !grant_valid));

    // R6: an accepted acknowledge adds one level to service
    assert_ack_adds_level_R6: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_req && !cfg_auto_eoi && !eoi_valid)
        |=> ($countones(srv_bits) == $past($countones(srv_bits)) + 1));

    // R6: the granted level had its request bit set
    assert_grant_was_pending_R6: assert property (@(posedge clk) disable iff (rst)
        (int_ack && int_req) |=> $past(req_bits[pend_top.idx]));
endmodule

// File: tb/tb_pic_core.sv
`timescale 1ns/1ps
module tb_pic_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = 8'h00;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic       cfg_level_trig = 1'b0;
    logic       cfg_rotate = 1'b0;
    logic       cfg_auto_eoi = 1'b0;
    logic       int_ack = 1'b0;
    logic       eoi_valid = 1'b0;
    logic       eoi_specific = 1'b0;
    logic [2:0] eoi_level = 3'd0;
    logic       int_req;
    logic       grant_valid;
    logic [2:0] grant_level;
    logic [7:0] req_bits;
    logic [7:0] srv_bits;
    logic [7:0] mask_bits;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [7:0] m_irr, m_isr, m_mask, m_prev;
    logic [2:0] m_low, m_glvl;
    logic       m_gv;

    always #4 clk = ~clk;

    pic_core dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cfg_level_trig(cfg_level_trig), .cfg_rotate(cfg_rotate), .cfg_auto_eoi(cfg_auto_eoi),
        .int_ack(int_ack), .eoi_valid(eoi_valid), .eoi_specific(eoi_specific),
        .eoi_level(eoi_level), .int_req(int_req), .grant_valid(grant_valid),
        .grant_level(grant_level), .req_bits(req_bits), .srv_bits(srv_bits),
        .mask_bits(mask_bits)
    );

    function automatic int b_rank(int lvl, logic [2:0] low);
        return (lvl - int'(low) - 1 + 16) % 8;
    endfunction

    // Most urgent set level of v under base `low`, or -1.
    function automatic int b_best(logic [7:0] v, logic [2:0] low);
        int best = -1;
        for (int i = 0; i < 8; i++) begin
            if (v[i] && (best < 0 || b_rank(i, low) < b_rank(best, low))) best = i;
        end
        return best;
    endfunction

    function automatic logic [2:0] b_eff_low();
        return cfg_rotate ? m_low : 3'd7;
    endfunction

    function automatic logic model_int();
        int p = b_best(m_irr & ~m_mask, b_eff_low());
        int s = b_best(m_isr, b_eff_low());
        return (p >= 0) && (s < 0 || b_rank(p, b_eff_low()) < b_rank(s, b_eff_low()));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        logic [7:0] clr, set, eclr, rise;
        logic       taken;
        int         p, s, tgt;
        if (rst) begin
            m_irr = 8'h00; m_isr = 8'h00; m_mask = 8'hFF; m_prev = 8'h00;
            m_low = 3'd7; m_gv = 1'b0; m_glvl = 3'd0;
            return;
        end
        p     = b_best(m_irr & ~m_mask, b_eff_low());
        s     = b_best(m_isr, b_eff_low());
        taken = int_ack && model_int();
        clr   = taken ? (8'h01 << p) : 8'h00;
        set   = (taken && !cfg_auto_eoi) ? (8'h01 << p) : 8'h00;
        tgt   = eoi_specific ? int'(eoi_level) : s;
        eclr  = (eoi_valid && tgt >= 0) ? ((8'h01 << tgt) & m_isr) : 8'h00;
        rise  = irq_in & ~m_prev;
        if (cfg_rotate) begin
            if (taken && cfg_auto_eoi) m_low = 3'(p);
            else if (eclr != 8'h00) m_low = 3'(tgt);
        end
        m_irr  = cfg_level_trig ? (irq_in & ~clr) : (((m_irr & ~clr) | rise) & irq_in);
        m_isr  = (m_isr & ~eclr) | set;
        if (mask_we) m_mask = mask_wdata;
        m_gv   = taken;
        if (taken) m_glvl = 3'(p);
        m_prev = irq_in;
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(cfg_level_trig ? "R4 req" : "R3 req", 32'(req_bits), 32'(m_irr));
        check("R6 srv", 32'(srv_bits), 32'(m_isr));
        check("R2 mask", 32'(mask_bits), 32'(m_mask));
        check("R5 int", 32'(int_req), 32'(model_int()));
        check("R6 grant_valid", 32'(grant_valid), 32'(m_gv));
        if (m_gv) check("R7 grant_level", 32'(grant_level), 32'(m_glvl));
        int_ack = 1'b0; eoi_valid = 1'b0; mask_we = 1'b0;
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        rst = 1'b1; step(); step();
        rst = 1'b0;
        check("R1 req", 32'(req_bits), 32'h00);
        check("R1 srv", 32'(srv_bits), 32'h00);
        check("R1 mask", 32'(mask_bits), 32'hFF);
        check("R1 int", 32'(int_req), 32'h0);

        // nesting under fixed priority, edge mode
        mask_we = 1'b1; mask_wdata = 8'h00; irq_in = 8'h28; step();
        check("R3 edge latch", 32'(req_bits), 32'h28);
        int_ack = 1'b1; step();
        check("R7 fixed winner", 32'(grant_level), 32'd3);
        check("R6 srv set", 32'(srv_bits), 32'h08);
        check("R6 req cleared", 32'(req_bits), 32'h20);
        check("R5 lower blocked", 32'(int_req), 32'h0);
        irq_in = 8'h2A; step();
        check("R5 higher raises", 32'(int_req), 32'h1);
        int_ack = 1'b1; step();
        check("R6 nested srv", 32'(srv_bits), 32'h0A);
        eoi_valid = 1'b1; eoi_specific = 1'b0; step();
        check("R9 nonspecific", 32'(srv_bits), 32'h08);
        eoi_valid = 1'b1; eoi_specific = 1'b1; eoi_level = 3'd3; step();
        check("R10 specific", 32'(srv_bits), 32'h00);
        check("R5 pending after eoi", 32'(int_req), 32'h1);
        mask_we = 1'b1; mask_wdata = 8'h20; step();
        check("R2 masked int", 32'(int_req), 32'h0);
        check("R2 masked still pending", 32'(req_bits), 32'h20);
        mask_we = 1'b1; mask_wdata = 8'h00; irq_in = 8'h0A; step();
        check("R12 withdrawn", 32'(req_bits), 32'h00);
        int_ack = 1'b1; step();
        check("R12 no service", 32'(srv_bits), 32'h00);
        check("R6 stray ack", 32'(grant_valid), 32'h0);
        irq_in = 8'h00; step();
        irq_in = 8'h02; step();
        check("R3 retrigger", 32'(req_bits), 32'h02);

        // level mode
        cfg_level_trig = 1'b1; irq_in = 8'h80; step();
        check("R4 follows", 32'(req_bits), 32'h80);
        irq_in = 8'h00; step();
        check("R4 drops", 32'(req_bits), 32'h00);

        // rotation
        cfg_rotate = 1'b1; irq_in = 8'h09; step();
        int_ack = 1'b1; step();
        check("R8 first winner", 32'(grant_level), 32'd0);
        eoi_valid = 1'b1; eoi_specific = 1'b0; step();
        int_ack = 1'b1; step();
        check("R8 rotated winner", 32'(grant_level), 32'd3);
        eoi_valid = 1'b1; eoi_specific = 1'b0; step();
        irq_in = 8'h00; cfg_rotate = 1'b0; step();

        // automatic retirement
        cfg_auto_eoi = 1'b1; irq_in = 8'h10; step();
        int_ack = 1'b1; step();
        check("R11 grant", 32'(grant_level), 32'd4);
        check("R11 srv empty", 32'(srv_bits), 32'h00);
        irq_in = 8'h00; cfg_auto_eoi = 1'b0; step();

        // random phases
        for (int ph = 0; ph < 15; ph++) begin
            cfg_level_trig = 1'($urandom % 2);
            cfg_rotate     = 1'($urandom % 2);
            cfg_auto_eoi   = 1'(($urandom % 4) == 0);
            for (int c = 0; c < 200; c++) begin
                if ($urandom % 3 == 0) irq_in = irq_in ^ (8'h01 << ($urandom % 8));
                int_ack      = 1'(($urandom % 3) == 0);
                eoi_valid    = 1'(($urandom % 6) == 0);
                eoi_specific = 1'($urandom % 2);
                eoi_level    = 3'($urandom % 8);
                mask_we      = 1'(($urandom % 20) == 0);
                mask_wdata   = 8'($urandom & $urandom);
                step();
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule